// File: doc/BRIEF.md
# Fractional feedback divider chain for a synthesizer loop

This block holds the two digital dividers that feed the phase detector of an indirect frequency synthesizer. A clock running at oscillator rate first passes through a fixed prescaler of ratio K. The prescaler's ticks drive a programmable counter whose modulus is N or N+1 for each output period. A first-order fractional accumulator picks between the two, so the average feedback ratio is K·(N + F/2^B). A second programmable counter divides the reference clock by R. When the loop is locked, the output frequency is K·(N + F/2^B)/R times the reference frequency.

The integer modulus, the fraction and the reference ratio come in as register-style control values. A new value takes effect only when its counter wraps, so a period already running always completes at its full length. Each divided output is a single pulse, one clock of its own domain wide, produced when the counter reaches its terminal count.

Top module: `fdiv_synth_divider`

## Requirements
- R1: While rst_ni is low, fb_o and ref_o are both 0, and the fraction accumulator restarts from 0.
- R2: With frac_i = 0, consecutive fb_o pulses are K·N clk_vco_i cycles apart, where K = PRESCALE (default 4) and N = int_mod_i.
- R3: Every fb_o pulse and every ref_o pulse is high for exactly one cycle of its own clock.
- R4: At every fb_o wrap, frac_i is added to a FRAC_W-bit accumulator modulo 2^FRAC_W. If the addition carries out, the period that follows lasts K·(N+1) cycles; otherwise it lasts K·N cycles.
- R5: With frac_i held at F for 2^FRAC_W consecutive feedback periods, exactly F of those periods use modulus N+1.
- R6: A change to int_mod_i or frac_i does not alter the period in progress. The new values are taken at the next feedback wrap.
- R7: A modulus value of 0 or 1 on int_mod_i or ref_div_i behaves exactly like 2.
- R8: Consecutive ref_o pulses are R clk_ref_i cycles apart, where R = ref_div_i. A new R is taken at the next reference wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco_i | input | 1 | Oscillator-rate clock to be divided |
| clk_ref_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| int_mod_i | input | INT_W | Integer modulus N of the programmable counter |
| frac_i | input | FRAC_W | Fraction F; average modulus is N + F/2^FRAC_W |
| ref_div_i | input | REF_W | Reference division ratio R |
| fb_o | output | 1 | Divided feedback pulse, clk_vco_i domain |
| ref_o | output | 1 | Divided reference pulse, clk_ref_i domain |

## Verification
The assertions assume that each control value is stable relative to the clock that samples it. In practice this means no control value changes within a setup window of the wrap edge, since there is no synchronizer between the register side and the two counting domains. The stimulus respects this by changing control values only on falling clock edges, and only after the pulse that marks a wrap has been observed. For the feedback path, a control change may come up to three cycles later. That is well before the next wrap, because the shortest feedback period is 2K cycles. The random section draws moduli that include 0 and 1, so the floor of 2 is exercised together with random fractions.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int unsigned MOD_FLOOR = 2;

  function automatic logic [15:0] clamp_mod(input logic [15:0] v);
    return (v < 16'(MOD_FLOOR)) ? 16'(MOD_FLOOR) : v;
  endfunction
endpackage

// File: rtl/fdiv_prescaler.sv
module fdiv_prescaler #(
  parameter int unsigned K = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (K == 1) begin : g_bypass
      logic en_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_q <= 1'b0;
        else         en_q <= 1'b1;
      end
      assign tick_o = en_q;
    end else begin : g_count
      localparam int unsigned CW = $clog2(K);
      logic [CW-1:0] cnt_q;
      logic          last;
      assign last = (cnt_q == CW'(K - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   cnt_q <= '0;
        else if (last) cnt_q <= '0;
        else           cnt_q <= cnt_q + CW'(1);
      end
      assign tick_o = last;

      // R2: the prescaler never ticks on two adjacent cycles
      p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/fdiv_frac_counter.sv
module fdiv_frac_counter import fdiv_pkg::*; #(
  parameter int unsigned NW = 8,
  parameter int unsigned FW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [NW-1:0] n_i,
  input  logic [FW-1:0] frac_i,
  output logic          pulse_o
);
  localparam int unsigned MW = NW + 1;

  logic [MW-1:0] cnt_q, mod_q, next_mod;
  logic [FW-1:0] acc_q;
  logic [FW:0]   sum;
  logic [NW-1:0] n_eff;
  logic          at_term, wrap, pulse_q;

  assign n_eff    = NW'(clamp_mod(16'(n_i)));
  assign sum      = {1'b0, acc_q} + {1'b0, frac_i};
  assign next_mod = {1'b0, n_eff} + MW'(sum[FW]);
  assign at_term  = (cnt_q == mod_q - MW'(1));
  assign wrap     = tick_i & at_term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      mod_q   <= MW'(MOD_FLOOR);
      acc_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= wrap;
      if (tick_i) begin
        if (at_term) begin
          cnt_q <= '0;
          mod_q <= next_mod;      // controls sampled only here
          acc_q <= sum[FW-1:0];
        end else begin
          cnt_q <= cnt_q + MW'(1);
        end
      end
    end
  end

  assign pulse_o = pulse_q;

  p_cnt_below_mod_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < mod_q);
  p_mod_floor_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_q >= MW'(MOD_FLOOR));
  p_mod_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(mod_q) && $stable(acc_q));
  p_fb_one_wide_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);
endmodule

// File: rtl/fdiv_ref_divider.sv
module fdiv_ref_divider import fdiv_pkg::*; #(
  parameter int unsigned RW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] r_i,
  output logic          pulse_o
);
  logic [RW-1:0] cnt_q, mod_q, r_eff;
  logic          at_term, pulse_q;

  assign r_eff   = RW'(clamp_mod(16'(r_i)));
  assign at_term = (cnt_q == mod_q - RW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      mod_q   <= RW'(MOD_FLOOR);
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= at_term;
      if (at_term) begin
        cnt_q <= '0;
        mod_q <= r_eff;
      end else begin
        cnt_q <= cnt_q + RW'(1);
      end
    end
  end

  assign pulse_o = pulse_q;

  p_ref_one_wide_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);
  p_ref_floor_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_q >= RW'(MOD_FLOOR));
  p_ref_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !at_term |=> $stable(mod_q));
endmodule

// File: rtl/fdiv_synth_divider.sv
module fdiv_synth_divider #(
  parameter int unsigned PRESCALE = 4,
  parameter int unsigned INT_W    = 8,
  parameter int unsigned FRAC_W   = 8,
  parameter int unsigned REF_W    = 8
) (
  input  logic              clk_vco_i,
  input  logic              clk_ref_i,
  input  logic              rst_ni,
  input  logic [INT_W-1:0]  int_mod_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [REF_W-1:0]  ref_div_i,
  output logic              fb_o,
  output logic              ref_o
);
  logic pre_tick;

  fdiv_prescaler #(.K(PRESCALE)) u_pre (
    .clk_i (clk_vco_i),
    .rst_ni(rst_ni),
    .tick_o(pre_tick)
  );

  fdiv_frac_counter #(.NW(INT_W), .FW(FRAC_W)) u_fb (
    .clk_i  (clk_vco_i),
    .rst_ni (rst_ni),
    .tick_i (pre_tick),
    .n_i    (int_mod_i),
    .frac_i (frac_i),
    .pulse_o(fb_o)
  );

  fdiv_ref_divider #(.RW(REF_W)) u_ref (
    .clk_i  (clk_ref_i),
    .rst_ni (rst_ni),
    .r_i    (ref_div_i),
    .pulse_o(ref_o)
  );
endmodule

// File: tb/tb_fdiv_synth_divider.sv
`timescale 1ns/1ps
module tb_fdiv_synth_divider;
  localparam int K  = 4;
  localparam int NW = 8;
  localparam int FW = 8;
  localparam int RW = 8;

  logic clk_vco_i = 1'b0, clk_ref_i = 1'b0, rst_ni = 1'b0;
  logic [NW-1:0] int_mod_i;
  logic [FW-1:0] frac_i;
  logic [RW-1:0] ref_div_i;
  logic fb_o, ref_o;

  fdiv_synth_divider #(.PRESCALE(K), .INT_W(NW), .FRAC_W(FW), .REF_W(RW)) dut (
    .clk_vco_i(clk_vco_i), .clk_ref_i(clk_ref_i), .rst_ni(rst_ni),
    .int_mod_i(int_mod_i), .frac_i(frac_i), .ref_div_i(ref_div_i),
    .fb_o(fb_o), .ref_o(ref_o));

  always #10 clk_vco_i = ~clk_vco_i;   // 50 MHz
  always #35 clk_ref_i = ~clk_ref_i;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int vcyc = 0, rcyc = 0;
  always @(posedge clk_vco_i) vcyc++;
  always @(posedge clk_ref_i) rcyc++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int clampm(input int v);
    return (v < 2) ? 2 : v;
  endfunction

  // feedback path model
  int acc_m = 0, exp_iv = 0, last_fb = 0;
  bit have_fb = 1'b0;

  task automatic fb_next(input string req, output int iv);
    int guard = 0;
    int sum;
    do begin @(negedge clk_vco_i); guard++; end while (!fb_o && guard < 20000);
    iv = vcyc - last_fb;
    last_fb = vcyc;
    if (have_fb) check(iv == exp_iv, req, iv, exp_iv);
    sum    = acc_m + int'(frac_i);
    acc_m  = sum % (1 << FW);
    exp_iv = K * (clampm(int'(int_mod_i)) + (sum >> FW));
    have_fb = 1'b1;
    @(negedge clk_vco_i);
    check(fb_o == 1'b0, "R3 fb width", int'(fb_o), 0);
  endtask

  // reference path model
  int exp_r = 0, last_r = 0;
  bit have_r = 1'b0;

  task automatic ref_next(input string req);
    int guard = 0;
    int iv;
    do begin @(negedge clk_ref_i); guard++; end while (!ref_o && guard < 2000);
    iv = rcyc - last_r;
    last_r = rcyc;
    if (have_r) check(iv == exp_r, req, iv, exp_r);
    exp_r = clampm(int'(ref_div_i));
    have_r = 1'b1;
    @(negedge clk_ref_i);
    check(ref_o == 1'b0, "R3 ref width", int'(ref_o), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int iv, longs;
    void'($urandom(32'd1234));
    int_mod_i = 8'd5; frac_i = '0; ref_div_i = 8'd6;
    repeat (4) begin
      @(negedge clk_vco_i);
      check(fb_o == 1'b0 && ref_o == 1'b0, "R1 outputs in reset", int'({fb_o, ref_o}), 0);
    end
    rst_ni = 1'b1;

    fork
      begin : vco_side
        fb_next("R2 first", iv);
        repeat (4) fb_next("R2 integer N=5", iv);
        int_mod_i = 8'd1;
        repeat (3) fb_next("R7 N=1 floor", iv);
        int_mod_i = 8'd0;
        repeat (3) fb_next("R7 N=0 floor", iv);
        // R6: change mid-period, running period keeps old length
        int_mod_i = 8'd9;
        fb_next("R6 setup", iv);
        repeat (3) @(negedge clk_vco_i);
        int_mod_i = 8'd2;
        fb_next("R6 mid-period change to 2", iv);
        frac_i = 8'd255;
        repeat (2) @(negedge clk_vco_i);
        fb_next("R6 frac change", iv);
        repeat (4) fb_next("R4 frac=255", iv);
        int_mod_i = 8'd3; frac_i = 8'd200;
        repeat (10) fb_next("R4 N=3 frac=200", iv);
        // R5: long periods over a full accumulator cycle
        int_mod_i = 8'd2; frac_i = 8'd77;
        fb_next("R4 to R5", iv);
        longs = 0;
        for (int i = 0; i < 256; i++) begin
          fb_next("R5 period", iv);
          if (iv == K * 3) longs++;
        end
        check(longs == 77, "R5 long period count", longs, 77);
        // constrained random
        for (int i = 0; i < 40; i++) begin
          int_mod_i = NW'($urandom_range(0, 12));
          frac_i    = FW'($urandom);
          fb_next("R4 random", iv);
          repeat ($urandom_range(0, 3)) @(negedge clk_vco_i);
        end
        fb_next("R4 random tail", iv);
      end
      begin : ref_side
        ref_next("R8 first");
        repeat (3) ref_next("R8 R=6");
        ref_div_i = 8'd1;
        repeat (3) ref_next("R7 R=1 floor");
        ref_div_i = 8'd0;
        repeat (2) ref_next("R7 R=0 floor");
        ref_div_i = 8'd255;
        repeat (2) ref_next("R8 R=255");
        for (int i = 0; i < 30; i++) begin
          ref_div_i = RW'($urandom_range(0, 20));
          ref_next("R8 random");
        end
        ref_next("R8 random tail");
      end
    join

    finish_run();
  end
endmodule